// File: doc/BRIEF.md
# Table Entry Address Walker

This block turns an entry index into the byte address of that entry inside an in-memory lookup table. The caller presents a table descriptor (base address, page size code, log2 of the entry size, and a flag that selects flat or indirect layout) together with the index. For a flat table the address is computed directly. For an indirect table the block fetches one 64-bit first-level pointer from memory, checks its valid flag, and adds the offset of the entry inside the second-level page that the pointer names.

Each request ends with a one-cycle completion pulse and a 2-bit outcome: an address, no valid second-level page, or a memory error on the pointer fetch. The block handles one request at a time and accepts the next only after it has returned to idle.

Top module: `tbl_entry_locator`

## Requirements
- R1: With `req_indirect` low, `rsp_done` rises in the cycle after acceptance with `rsp_code` 0 and `rsp_addr` = base + index × entry size (modulo 2^ADDR_W), and `mem_rd_req` stays low for the whole request.
- R2: `req_pgsz` selects the page size: 0 = 4 KB, 1 = 16 KB, 2 = 64 KB, 3 = 64 KB; the entry size is 2^`req_esz_log2` bytes, with `req_esz_log2` from 0 to 7.
- R3: With `req_indirect` high, the block raises `mem_rd_req` in the cycle after acceptance with `mem_rd_addr` = base + (index / (page size / 8)) × 8, and holds both unchanged until `mem_rd_ack` is seen.
- R4: A pointer fetch answered with `mem_rd_err` high completes with `rsp_code` 2 and `rsp_addr` 0.
- R5: A pointer fetch without error whose bit 63 is 0 completes with `rsp_code` 1 and `rsp_addr` 0.
- R6: A pointer fetch without error whose bit 63 is 1 completes with `rsp_code` 0 and `rsp_addr` = pointer bits [50:0] + (index mod (page size / entry size)) × entry size; pointer bits 62 to 51 have no effect.
- R7: `rsp_done` is high for exactly one cycle per request, in the cycle after `mem_rd_ack` for indirect requests, and `rsp_code` is never 3 while it is high.
- R8: `req_ready` is high only while idle; a `req_valid` presented while `req_ready` is low is ignored and does not change the result of the request in progress.
- R9: After reset `req_ready` is high and `rsp_done` and `mem_rd_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this edge if valid |
| req_base | input | ADDR_W | Table base address |
| req_pgsz | input | 2 | Page size code |
| req_esz_log2 | input | 3 | log2 of the entry size in bytes |
| req_indirect | input | 1 | 1 = two-level table, 0 = flat |
| req_index | input | IDX_W | Entry index |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_code | output | 2 | 0 address, 1 no page, 2 memory error |
| rsp_addr | output | ADDR_W | Entry address, 0 unless code is 0 |
| mem_rd_req | output | 1 | Pointer fetch request, held until ack |
| mem_rd_addr | output | ADDR_W | Pointer fetch address |
| mem_rd_ack | input | 1 | Fetch response present |
| mem_rd_data | input | 64 | Fetched pointer, little-endian word |
| mem_rd_err | input | 1 | Fetch failed |

## Verification
Random descriptors over every page-size code and entry size are run in both layouts, with random base, index and pointer values, and memory answers delayed by zero to three cycles; these separate the shift amounts used for slot selection from those used for the in-page offset. Directed cases place the index exactly on a slot boundary and at its maximum, return a pointer with its unused upper bits set, return a cleared valid flag and an error, and drive a second request while busy, which tells apart the three outcomes and shows that bits above 50 and busy-time requests leave the result untouched.

// File: rtl/tel_pkg.sv
package tel_pkg;
  localparam int L1_SLOT_LOG2 = 3;
  localparam int L2_PTR_W     = 51;
  localparam int L1_VALID_BIT = 63;
  localparam int SH_W         = 5;

  typedef enum logic [1:0] {
    TEL_ADDR   = 2'd0,
    TEL_NOPAGE = 2'd1,
    TEL_MEMERR = 2'd2
  } tel_code_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_DONE = 2'd2
  } tel_state_e;

  function automatic logic [SH_W-1:0] page_log2(input logic [1:0] code);
    case (code)
      2'd0:    page_log2 = SH_W'(12);
      2'd1:    page_log2 = SH_W'(14);
      default: page_log2 = SH_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/tel_geom.sv
module tel_geom
  import tel_pkg::*;
#(
  parameter int ADDR_W = 52,
  parameter int IDX_W  = 20
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [1:0]        pgsz,
  input  logic [2:0]        esz_log2,
  input  logic [IDX_W-1:0]  index,
  output logic [ADDR_W-1:0] flat_addr,
  output logic [ADDR_W-1:0] l1_addr,
  output logic [ADDR_W-1:0] l2_off
);
  logic [SH_W-1:0]   pg_lg;
  logic [SH_W-1:0]   slot_sh;
  logic [SH_W-1:0]   epp_lg;
  logic [ADDR_W-1:0] idx_ext;
  logic [ADDR_W-1:0] slot;
  logic [ADDR_W-1:0] in_page_mask;

  always_comb begin
    pg_lg        = page_log2(pgsz);
    slot_sh      = pg_lg - SH_W'(L1_SLOT_LOG2);
    epp_lg       = pg_lg - {2'b00, esz_log2};
    idx_ext      = {{(ADDR_W-IDX_W){1'b0}}, index};
    flat_addr    = base + (idx_ext << esz_log2);
    slot         = idx_ext >> slot_sh;
    l1_addr      = base + (slot << L1_SLOT_LOG2);
    in_page_mask = (ADDR_W'(1) << epp_lg) - ADDR_W'(1);
    l2_off       = (idx_ext & in_page_mask) << esz_log2;
  end
endmodule

// File: rtl/tel_l1_decode.sv
module tel_l1_decode
  import tel_pkg::*;
#(
  parameter int ADDR_W = 52
) (
  input  logic [63:0]       rd_data,
  input  logic              rd_err,
  input  logic [ADDR_W-1:0] l2_off,
  output tel_code_e         code,
  output logic [ADDR_W-1:0] addr
);
  always_comb begin
    if (rd_err) begin
      code = TEL_MEMERR;
      addr = '0;
    end else if (!rd_data[L1_VALID_BIT]) begin
      code = TEL_NOPAGE;
      addr = '0;
    end else begin
      code = TEL_ADDR;
      addr = ADDR_W'(rd_data[L2_PTR_W-1:0]) + l2_off;
    end
  end
endmodule

// File: rtl/tel_fsm.sv
module tel_fsm
  import tel_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_indirect,
  input  logic mem_rd_ack,
  output logic req_ready,
  output logic accept,
  output logic capture,
  output logic mem_rd_req,
  output logic done
);
  tel_state_e state_q, state_d;

  always_comb begin
    req_ready  = (state_q == ST_IDLE);
    mem_rd_req = (state_q == ST_READ);
    done       = (state_q == ST_DONE);
    accept     = req_ready && req_valid;
    capture    = mem_rd_req && mem_rd_ack;
    state_d    = state_q;
    case (state_q)
      ST_IDLE: if (accept) state_d = req_indirect ? ST_READ : ST_DONE;
      ST_READ: if (capture) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/tbl_entry_locator.sv
module tbl_entry_locator
  import tel_pkg::*;
#(
  parameter int ADDR_W = 52,
  parameter int IDX_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [1:0]        req_pgsz,
  input  logic [2:0]        req_esz_log2,
  input  logic              req_indirect,
  input  logic [IDX_W-1:0]  req_index,
  output logic              rsp_done,
  output logic [1:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_ack,
  input  logic [63:0]       mem_rd_data,
  input  logic              mem_rd_err
);
  logic              accept, capture;
  logic [ADDR_W-1:0] flat_addr, l1_addr, l2_off;
  tel_code_e         dec_code;
  logic [ADDR_W-1:0] dec_addr;

  logic [ADDR_W-1:0] l1_addr_q, l1_addr_d;
  logic [ADDR_W-1:0] off_q, off_d;
  logic [ADDR_W-1:0] res_addr_q, res_addr_d;
  tel_code_e         res_code_q, res_code_d;
  logic              req_en, res_en;

  tel_fsm u_fsm (
    .clk, .rst_n, .req_valid, .req_indirect, .mem_rd_ack,
    .req_ready, .accept, .capture, .mem_rd_req, .done(rsp_done)
  );

  tel_geom #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_geom (
    .base(req_base), .pgsz(req_pgsz), .esz_log2(req_esz_log2),
    .index(req_index), .flat_addr, .l1_addr, .l2_off
  );

  tel_l1_decode #(.ADDR_W(ADDR_W)) u_dec (
    .rd_data(mem_rd_data), .rd_err(mem_rd_err), .l2_off(off_q),
    .code(dec_code), .addr(dec_addr)
  );

  always_comb begin
    req_en     = accept;
    res_en     = (accept && !req_indirect) || capture;
    l1_addr_d  = l1_addr;
    off_d      = l2_off;
    res_addr_d = capture ? dec_addr : flat_addr;
    res_code_d = capture ? dec_code : TEL_ADDR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l1_addr_q  <= '0;
      off_q      <= '0;
      res_addr_q <= '0;
      res_code_q <= TEL_ADDR;
    end else begin
      if (req_en) begin
        l1_addr_q <= l1_addr_d;
        off_q     <= off_d;
      end
      if (res_en) begin
        res_addr_q <= res_addr_d;
        res_code_q <= res_code_d;
      end
    end
  end

  assign mem_rd_addr = l1_addr_q;
  assign rsp_addr    = res_addr_q;
  assign rsp_code    = res_code_q;
endmodule

// File: rtl/tel_checker.sv
module tel_checker #(
  parameter int ADDR_W = 52
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_indirect,
  input logic              rsp_done,
  input logic [1:0]        rsp_code,
  input logic [ADDR_W-1:0] rsp_addr,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_ack
);
  logic ind_lat;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ind_lat <= 1'b0;
    else if (req_valid && req_ready) ind_lat <= req_indirect;
  end

  a_r1_flat_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_indirect) |=> rsp_done);
  a_r1_flat_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> ind_lat);
  a_r3_hold_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr)));
  a_r4_err_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_code == 2'd2) |-> (rsp_addr == '0));
  a_r5_nopage_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && rsp_code == 2'd1) |-> (rsp_addr == '0));
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r7_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> (rsp_code != 2'd3));
  a_r7_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_rd_ack) |=> rsp_done);
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done || mem_rd_req) |-> !req_ready);
endmodule

bind tbl_entry_locator tel_checker #(.ADDR_W(ADDR_W)) u_tel_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_indirect(req_indirect), .rsp_done(rsp_done), .rsp_code(rsp_code),
  .rsp_addr(rsp_addr), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
  .mem_rd_ack(mem_rd_ack)
);

// File: tb/tbl_entry_locator_tb_top.sv
`timescale 1ns/1ps
module tbl_entry_locator_tb_top;
  localparam int AW = 52;
  localparam int IW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_base = '0;
  logic [1:0]    req_pgsz = '0;
  logic [2:0]    req_esz_log2 = '0;
  logic          req_indirect = 1'b0;
  logic [IW-1:0] req_index = '0;
  logic          rsp_done;
  logic [1:0]    rsp_code;
  logic [AW-1:0] rsp_addr;
  logic          mem_rd_req;
  logic [AW-1:0] mem_rd_addr;
  logic          mem_rd_ack = 1'b0;
  logic [63:0]   mem_rd_data = '0;
  logic          mem_rd_err = 1'b0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tbl_entry_locator #(.ADDR_W(AW), .IDX_W(IW)) dut_i (.*);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic longint unsigned pg_bytes(input logic [1:0] c);
    case (c)
      2'd0: return 64'd4096;
      2'd1: return 64'd16384;
      default: return 64'd65536;
    endcase
  endfunction

  function automatic logic [AW-1:0] exp_flat(input logic [AW-1:0] b,
      input logic [2:0] e, input logic [IW-1:0] i);
    longint unsigned eb = 64'd1 << e;
    return AW'(64'(b) + 64'(i) * eb);
  endfunction

  function automatic logic [AW-1:0] exp_l1(input logic [AW-1:0] b,
      input logic [1:0] p, input logic [IW-1:0] i);
    return AW'(64'(b) + (64'(i) / (pg_bytes(p) / 8)) * 8);
  endfunction

  function automatic logic [AW-1:0] exp_l2(input logic [63:0] d,
      input logic [1:0] p, input logic [2:0] e, input logic [IW-1:0] i);
    longint unsigned eb = 64'd1 << e;
    longint unsigned pg = 64'(d[50:0]);
    return AW'(pg + (64'(i) % (pg_bytes(p) / eb)) * eb);
  endfunction

  task automatic run(input logic [AW-1:0] b, input logic [1:0] p,
      input logic [2:0] e, input bit ind, input logic [IW-1:0] i,
      input logic [63:0] d, input bit err, input int dly, input bit noise);
    logic [1:0]    ec;
    logic [AW-1:0] ea;
    @(negedge clk);
    req_valid = 1'b1; req_base = b; req_pgsz = p; req_esz_log2 = e;
    req_indirect = ind; req_index = i;
    chk(req_ready == 1'b1, "R8 ready while idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    if (noise) begin
      req_base = ~b; req_index = ~i; req_indirect = ~ind; req_pgsz = ~p;
    end else req_valid = 1'b0;
    if (ind) begin
      chk(mem_rd_req == 1'b1, "R3 fetch issued", 64'(mem_rd_req), 64'd1);
      chk(mem_rd_addr == exp_l1(b, p, i), "R3 fetch address",
          64'(mem_rd_addr), 64'(exp_l1(b, p, i)));
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        chk(mem_rd_req && !rsp_done && mem_rd_addr == exp_l1(b, p, i),
            "R3 fetch held", 64'(mem_rd_addr), 64'(exp_l1(b, p, i)));
      end
      mem_rd_ack = 1'b1; mem_rd_data = d; mem_rd_err = err;
      @(negedge clk);
      mem_rd_ack = 1'b0; mem_rd_data = '0; mem_rd_err = 1'b0;
      if (err) begin ec = 2'd2; ea = '0; end
      else if (!d[63]) begin ec = 2'd1; ea = '0; end
      else begin ec = 2'd0; ea = exp_l2(d, p, e, i); end
    end else begin
      chk(mem_rd_req == 1'b0, "R1 no fetch for flat", 64'(mem_rd_req), 64'd0);
      ec = 2'd0; ea = exp_flat(b, e, i);
    end
    req_valid = 1'b0;
    chk(rsp_done == 1'b1, "R7 done raised", 64'(rsp_done), 64'd1);
    chk(rsp_code == ec, ind ? (err ? "R4 code" : "R5/R6 code") : "R1 code",
        64'(rsp_code), 64'(ec));
    chk(rsp_addr == ea, ind ? (err ? "R4 addr" : "R5/R6 addr") : "R1 R2 addr",
        64'(rsp_addr), 64'(ea));
    @(negedge clk);
    chk(!rsp_done && req_ready, "R7 R8 single pulse then idle",
        64'({rsp_done, req_ready}), 64'b01);
  endtask

  initial begin
    logic [AW-1:0] b;
    logic [63:0]   d;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk(req_ready && !rsp_done && !mem_rd_req, "R9 reset state",
        64'({req_ready, rsp_done, mem_rd_req}), 64'b100);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run(52'h0_1000_0000, 2'd0, 3'd3, 1'b0, '0, '0, 1'b0, 0, 1'b0);          // R1 index 0
    run(52'hF_FFFF_FFFF_FF00, 2'd2, 3'd7, 1'b0, '1, '0, 1'b0, 0, 1'b0);     // R1 wrap, max index
    run(52'h0_0040_0000, 2'd0, 3'd3, 1'b1, IW'(512), 64'h8000_0000_0020_0000, 1'b0, 0, 1'b0); // R2 4K boundary
    run(52'h0_0040_0000, 2'd1, 3'd4, 1'b1, IW'(2048), 64'h8000_0000_0030_0000, 1'b0, 1, 1'b0); // R2 16K boundary
    run(52'h0_0040_0000, 2'd3, 3'd4, 1'b1, IW'(8191), 64'h8000_0000_0050_0000, 1'b0, 2, 1'b0); // R2 code 3 = 64K
    run(52'h0_0080_0000, 2'd2, 3'd5, 1'b1, IW'(77), 64'hFFF8_0000_0060_0000, 1'b0, 0, 1'b0);  // R6 high bits ignored
    run(52'h0_0080_0000, 2'd2, 3'd3, 1'b1, IW'(5), 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 1, 1'b0);   // R5 invalid
    run(52'h0_0080_0000, 2'd0, 3'd3, 1'b1, IW'(5), 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 3, 1'b0);   // R4 error
    run(52'h0_0123_4560, 2'd1, 3'd2, 1'b0, IW'(999), '0, 1'b0, 0, 1'b1);    // R8 flat busy noise
    run(52'h0_0123_4560, 2'd1, 3'd2, 1'b1, IW'(999), 64'h8000_0000_0070_0000, 1'b0, 2, 1'b1); // R8 indirect noise
    // random mix
    for (int n = 0; n < 80; n++) begin
      b = AW'({$urandom, $urandom});
      d = {$urandom, $urandom};
      d[63] = ($urandom_range(0, 3) != 0);
      run(b, 2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
          1'($urandom_range(0, 1)), IW'($urandom), d,
          ($urandom_range(0, 7) == 0), $urandom_range(0, 3),
          1'($urandom_range(0, 1)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual %0d expected 0", 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule